// File: doc/BRIEF.md
# Per-Region Transaction Ordering Gate

This block sits between an ingress request stream and a memory port. Each request names its own ordering mode, which comes from the region it targets. The request also carries a relaxed-ordering attribute bit. The gate decides whether the read or write at the head of the stream may issue now or must wait.

To make that decision, the gate counts outstanding writes and outstanding transactions of any kind. Issued requests raise these counts, and completion pulses from the memory side lower them.

The gate has no storage on its path. A request that is allowed passes straight through to the issue port in the same cycle. A request that is not allowed stays at the head of the stream, and nothing behind it can go ahead of it.

Top module: `order_gate`

## Requirements
- R1: Mode encoding is 2'b00 for unordered, 2'b01 for strict and 2'b10 for obey-packet. In unordered mode a write issues even while earlier writes are outstanding.
- R2: In unordered mode a read is held until no write is outstanding.
- R3: In strict mode a read or a write is held until no transaction of either type is outstanding.
- R4: In obey-packet mode, a write with the relaxed bit clear is held until no write is outstanding. A write with the relaxed bit set issues without waiting. A read is held until no write is outstanding.
- R5: Mode value 2'b11 behaves exactly as strict.
- R6: The mode is taken from each request, so consecutive requests with different modes are gated differently against the same outstanding state.
- R7: Outstanding writes and outstanding transactions are each limited to 15. A request that would push either count past 15 is held.
- R8: A completion pulse with a write tag (cplIsWrite=1) retires one write. A pulse with a read tag (cplIsWrite=0) retires one read. A completion of a type with nothing outstanding changes no count and sets the cplErr output, which stays set until reset.
- R9: A request issues in the same cycle as the completion that retires its last blocking transaction.
- R10: Requests leave in arrival order. reqReady is high only in a cycle where the request issues. issueValid is high only with reqValid, and issueIsWrite and issueTag equal the request fields. A held request keeps issueValid and reqReady low.
- R11: After reset nothing is outstanding, cplErr is low, and a request of any mode issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Head request present |
| reqReady | output | 1 | Head request accepted (issued) this cycle |
| reqIsWrite | input | 1 | 1 = write, 0 = read |
| reqMode | input | 2 | Ordering mode of the targeted region |
| reqRelaxed | input | 1 | Relaxed-ordering attribute of the packet |
| reqTag | input | TAG_W | Opaque request identifier |
| issueValid | output | 1 | Request offered to the memory port |
| issueReady | input | 1 | Memory port accepts the offer |
| issueIsWrite | output | 1 | Type of the issued request |
| issueTag | output | TAG_W | Identifier of the issued request |
| cplValid | input | 1 | One-cycle completion pulse |
| cplIsWrite | input | 1 | Completion type: 1 = write, 0 = read |
| cplErr | output | 1 | Sticky flag for a completion with nothing outstanding |

## Verification
The hardest state to reach from the ports is a request arriving in the exact cycle that a completion retires its last blocker. At 15 outstanding, the same timing applies to a request arriving just as a completion frees one slot. The bench drives the blocked request and the completion pulse on the same falling edge. It then checks that the offer is visible before the next rising edge. To reach the count limit, it first issues fifteen writes, and separately fifteen reads, back to back. The completion-error case is reached by retiring a write while only a read is outstanding. A strict request must then still wait on that read.

// File: rtl/order_gate_pkg.sv
package order_gate_pkg;

  typedef enum logic [1:0] {
    MODE_LOOSE  = 2'b00,
    MODE_STRICT = 2'b01,
    MODE_PKT    = 2'b10,
    MODE_RSVD   = 2'b11
  } ordMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic incWr;
    logic incRd;
    logic decWr;
    logic decRd;
    logic setErr;
  } gateStb_t;

endpackage

// File: rtl/order_gate_ctrl.sv
module order_gate_ctrl
  import order_gate_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             reqValid,
  input  logic             reqIsWrite,
  input  logic [1:0]       reqMode,
  input  logic             reqRelaxed,
  input  logic             issueReady,
  input  logic             cplValid,
  input  logic             cplIsWrite,
  input  logic [CNT_W-1:0] wrCnt,
  input  logic [CNT_W-1:0] totCnt,
  output logic             allowed,
  output gateStb_t         stb
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] rdCnt, wrEff, totEff;
  logic cplWrOk, cplRdOk, orderOk, roomOk, fire;
  ordMode_e mode;

  assign rdCnt   = totCnt - wrCnt;
  assign cplWrOk = cplValid &&  cplIsWrite && (wrCnt != '0);
  assign cplRdOk = cplValid && !cplIsWrite && (rdCnt != '0);
  // counts as they stand once this cycle's completion is applied
  assign wrEff   = wrCnt  - CNT_W'(cplWrOk);
  assign totEff  = totCnt - CNT_W'(cplWrOk || cplRdOk);
  assign mode    = ordMode_e'(reqMode);

  always_comb begin
    unique case (mode)
      MODE_LOOSE: orderOk = reqIsWrite ? 1'b1 : (wrEff == '0);
      MODE_PKT:   orderOk = (reqIsWrite && reqRelaxed) ? 1'b1 : (wrEff == '0);
      default:    orderOk = (totEff == '0);
    endcase
  end

  assign roomOk  = (totEff != CNT_MAX) && (!reqIsWrite || (wrEff != CNT_MAX));
  assign allowed = orderOk && roomOk;
  assign fire    = reqValid && allowed && issueReady;

  always_comb begin
    stb.incWr  = fire &&  reqIsWrite;
    stb.incRd  = fire && !reqIsWrite;
    stb.decWr  = cplWrOk;
    stb.decRd  = cplRdOk;
    stb.setErr = cplValid && !cplWrOk && !cplRdOk;
  end
endmodule

// File: rtl/order_gate_dp.sv
module order_gate_dp
  import order_gate_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  gateStb_t         stb,
  output logic [CNT_W-1:0] wrCnt,
  output logic [CNT_W-1:0] totCnt,
  output logic             errFlag
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic incTot, decTot;
  assign incTot = stb.incWr || stb.incRd;
  assign decTot = stb.decWr || stb.decRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt   <= '0;
      totCnt  <= '0;
      errFlag <= 1'b0;
    end else begin
      if (stb.incWr && !stb.decWr && wrCnt != CNT_MAX) wrCnt <= wrCnt + 1'b1;
      else if (stb.decWr && !stb.incWr && wrCnt != '0) wrCnt <= wrCnt - 1'b1;
      if (incTot && !decTot && totCnt != CNT_MAX) totCnt <= totCnt + 1'b1;
      else if (decTot && !incTot && totCnt != '0) totCnt <= totCnt - 1'b1;
      if (stb.setErr) errFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/order_gate.sv
module order_gate
  import order_gate_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic             reqIsWrite,
  input  logic [1:0]       reqMode,
  input  logic             reqRelaxed,
  input  logic [TAG_W-1:0] reqTag,
  output logic             issueValid,
  input  logic             issueReady,
  output logic             issueIsWrite,
  output logic [TAG_W-1:0] issueTag,
  input  logic             cplValid,
  input  logic             cplIsWrite,
  output logic             cplErr
);
  gateStb_t         stb;
  logic             allowed;
  logic [CNT_W-1:0] wrCnt, totCnt;

  order_gate_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .reqValid(reqValid), .reqIsWrite(reqIsWrite), .reqMode(reqMode),
    .reqRelaxed(reqRelaxed), .issueReady(issueReady), .cplValid(cplValid),
    .cplIsWrite(cplIsWrite), .wrCnt(wrCnt), .totCnt(totCnt),
    .allowed(allowed), .stb(stb)
  );

  order_gate_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrCnt(wrCnt), .totCnt(totCnt), .errFlag(cplErr)
  );

  assign issueValid   = reqValid && allowed;
  assign reqReady     = issueValid && issueReady;
  assign issueIsWrite = reqIsWrite;
  assign issueTag     = reqTag;
endmodule

// File: rtl/order_gate_chk.sv
module order_gate_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic             reqIsWrite,
  input logic [1:0]       reqMode,
  input logic             issueValid,
  input logic             issueReady,
  input logic             issueIsWrite,
  input logic             cplValid,
  input logic             cplIsWrite,
  input logic             cplErr,
  input logic [CNT_W-1:0] wrCnt,
  input logic [CNT_W-1:0] totCnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic fire;
  assign fire = issueValid && issueReady;

  // R2
  read_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire && !reqIsWrite |-> wrCnt == '0 || (wrCnt == 1 && cplValid && cplIsWrite));

  // R3
  strict_wait_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire && reqMode[0] |-> totCnt == '0 || (totCnt == 1 && cplValid));

  // R7
  wr_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire && reqIsWrite |-> wrCnt != CNT_MAX || (cplValid && cplIsWrite));

  // R8
  cnt_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt <= totCnt);

  // R8
  bad_cpl_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplValid && cplIsWrite && wrCnt == '0 |=> cplErr);

  // R8
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    cplErr |=> cplErr);

  // R10
  pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> reqValid && issueIsWrite == reqIsWrite);

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> issueValid && issueReady);
endmodule

bind order_gate order_gate_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqIsWrite(reqIsWrite), .reqMode(reqMode), .issueValid(issueValid),
  .issueReady(issueReady), .issueIsWrite(issueIsWrite), .cplValid(cplValid),
  .cplIsWrite(cplIsWrite), .cplErr(cplErr), .wrCnt(wrCnt), .totCnt(totCnt)
);

// File: tb/order_gate_tb_top.sv
module order_gate_tb_top;
  localparam int TAG_W = 8;
  localparam logic [1:0] UNO = 2'b00, STR = 2'b01, PKT = 2'b10, RSV = 2'b11;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqIsWrite = 0, reqRelaxed = 0, issueReady = 1;
  logic cplValid = 0, cplIsWrite = 0;
  logic [1:0] reqMode = 0;
  logic [TAG_W-1:0] reqTag = 0;
  logic reqReady, issueValid, issueIsWrite, cplErr;
  logic [TAG_W-1:0] issueTag;
  int nRun = 0, nFail = 0;

  always #2.5 clk = ~clk;

  order_gate #(.CNT_W(4), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqIsWrite(reqIsWrite), .reqMode(reqMode), .reqRelaxed(reqRelaxed),
    .reqTag(reqTag), .issueValid(issueValid), .issueReady(issueReady),
    .issueIsWrite(issueIsWrite), .issueTag(issueTag), .cplValid(cplValid),
    .cplIsWrite(cplIsWrite), .cplErr(cplErr)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // one cycle: drive on falling edge, check combinational outcome, pass a rising edge
  task automatic step(input logic rv, input logic wr, input logic [1:0] md,
                      input logic rel, input logic cv, input logic cw,
                      input logic expGo, input string rq);
    @(negedge clk);
    reqValid = rv; reqIsWrite = wr; reqMode = md; reqRelaxed = rel;
    reqTag = reqTag + 1'b1; cplValid = cv; cplIsWrite = cw;
    #1;
    chk(issueValid === expGo && reqReady === expGo, rq,
        {issueValid, reqReady}, {expGo, expGo});
    if (expGo) chk(issueTag === reqTag && issueIsWrite === wr, {rq, " R10 fields"},
                   {issueTag, issueIsWrite}, {reqTag, wr});
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 0; cplValid = 0;
  endtask

  task automatic cpl(input logic cw);
    step(0, 0, UNO, 0, 1, cw, 0, "cpl");
    idle();
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(issueValid === 0 && reqReady === 0 && cplErr === 0, "R11 reset outputs",
        {issueValid, reqReady, cplErr}, 0);
    step(1, 1, STR, 0, 0, 0, 1, "R11 strict write after reset");
    cpl(1);
  endtask

  task automatic t_unordered();
    for (int i = 0; i < 3; i++) step(1, 1, UNO, 0, 0, 0, 1, "R1 unordered write");
    step(1, 0, UNO, 0, 0, 0, 0, "R2 read blocked by writes");
    step(1, 0, UNO, 0, 1, 1, 0, "R2 read still blocked");
    step(1, 0, UNO, 0, 1, 1, 0, "R10 held read stays held");
    step(1, 0, UNO, 0, 1, 1, 1, "R9 read with last write completion");
    idle(); cpl(0);
  endtask

  task automatic t_strict();
    step(1, 0, STR, 0, 0, 0, 1, "R3 strict read idle");
    step(1, 1, STR, 0, 0, 0, 0, "R3 strict write behind read");
    step(1, 1, STR, 0, 1, 0, 1, "R9 strict write on completion");
    idle(); cpl(1);
    step(1, 1, RSV, 0, 0, 0, 1, "R5 mode3 write idle");
    step(1, 0, RSV, 0, 0, 0, 0, "R5 mode3 read behind write");
    step(1, 1, RSV, 1, 0, 0, 0, "R5 mode3 ignores relaxed");
    idle(); cpl(1);
    step(1, 0, RSV, 0, 0, 0, 1, "R5 mode3 read after drain");
    idle(); cpl(0);
  endtask

  task automatic t_obey();
    step(1, 1, PKT, 0, 0, 0, 1, "R4 ordered write idle");
    step(1, 1, PKT, 0, 0, 0, 0, "R4 ordered write behind write");
    step(1, 1, PKT, 1, 0, 0, 1, "R4 relaxed write passes");
    step(1, 0, PKT, 0, 0, 0, 0, "R4 read behind writes");
    idle(); cpl(1); cpl(1);
    step(1, 0, PKT, 0, 0, 0, 1, "R4 read after drain");
    idle(); cpl(0);
  endtask

  task automatic t_mixed();
    step(1, 1, UNO, 0, 0, 0, 1, "R6 first write");
    step(1, 1, STR, 0, 0, 0, 0, "R6 strict write blocked");
    step(1, 1, UNO, 0, 0, 0, 1, "R6 unordered write passes");
    step(1, 1, PKT, 1, 0, 0, 1, "R6 relaxed write passes");
    idle(); cpl(1); cpl(1); cpl(1);
  endtask

  task automatic t_limit();
    for (int i = 0; i < 15; i++) step(1, 1, UNO, 0, 0, 0, 1, "R7 write fill");
    step(1, 1, UNO, 0, 0, 0, 0, "R7 16th write held");
    step(1, 1, UNO, 0, 1, 1, 1, "R7 write on freed slot");
    idle();
    for (int i = 0; i < 15; i++) cpl(1);
    for (int i = 0; i < 15; i++) step(1, 0, UNO, 0, 0, 0, 1, "R7 read fill");
    step(1, 0, UNO, 0, 0, 0, 0, "R7 16th read held");
    step(1, 0, UNO, 0, 1, 0, 1, "R7 read on freed slot");
    idle();
    for (int i = 0; i < 15; i++) cpl(0);
    step(1, 0, STR, 0, 0, 0, 1, "R8 all retired");
    idle(); cpl(0);
  endtask

  task automatic t_err();
    @(negedge clk); #1;
    chk(cplErr === 0, "R8 no error yet", cplErr, 0);
    step(1, 0, UNO, 0, 0, 0, 1, "R8 read out");
    idle(); cpl(1);
    @(negedge clk); #1;
    chk(cplErr === 1, "R8 bad completion flagged", cplErr, 1);
    step(1, 1, STR, 0, 0, 0, 0, "R8 bad completion ignored");
    idle(); cpl(0);
    step(1, 1, STR, 0, 0, 0, 1, "R8 strict after real completion");
    idle(); cpl(1);
    @(negedge clk); #1;
    chk(cplErr === 1, "R8 flag sticky", cplErr, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    t_reset();
    t_unordered();
    t_strict();
    t_obey();
    t_mixed();
    t_limit();
    t_err();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule